// File: doc/BRIEF.md
# Delayed Interrupt Enable and Flag Controller

This block holds a 16-source interrupt controller's enable mask, request flags and master enable. Software reaches them through a byte-wide register port. The controller reproduces a short propagation delay between a change and its effect.

Neither software writes nor peripheral request pulses touch the live registers directly. Each one lands in a shadow copy and restarts a three-cycle update window. During that window, every cycle copies the shadows into the live registers. In the same cycle, a one-bit pending history and a two-bit line history each shift in the current live state.

The halt-wake output comes from the newest pending history bit. The processor IRQ line comes from the older bit of the line history, so it trails wake by one cycle. A separate delayed-request input arms a single-shot timer. When the timer expires, it sets a chosen set of flags.

Top module: `irq_delay_ctrl`

## Requirements
- R1: After reset, haltWake and irqLine are 0 and every register offset reads 0.
- R2: Register offsets are as follows. Enable low byte is at 0x200 and high byte at 0x201. Flag low byte is at 0x202 and high byte at 0x203. The master enable is at 0x208, and only its bit 0 is stored; bits 7..1 read 0. Offsets 0x206, 0x207, 0x209, 0x20A and 0x20B always read 0, and writes to them change no register.
- R3: A write to a flag byte clears every flag whose data bit is 1 and leaves all other flags unchanged. Each byte acts on its own eight flags.
- R4: A register write accepted at clock edge k becomes visible on the read port after edge k+1.
- R5: Each enable, flag or master-enable write, and each cycle with any request bit set, restarts the update window at 3 cycles. Live registers and outputs change only while the window is open.
- R6: haltWake becomes 1 two edges after the shadow change that makes (enable AND flag) nonzero. It falls the same way once the last common bit is gone.
- R7: irqLine follows one cycle after haltWake whenever the master enable is set.
- R8: With the master enable at 0, irqLine stays 0 even while haltWake is 1.
- R9: Suppose a delayed load with count N≥1 and mask M is accepted at edge L. Then M is ORed into the shadow flags at edge L+N and is readable after edge L+N+1. A load with count 0 never sets anything. A newer load replaces a pending one.
- R10: When a flag clear and a request for the same bit arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Byte write strobe |
| regAddr | input | 10 | Byte offset for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data of the live registers |
| reqPulse | input | 16 | Per-source request pulses, one per cycle |
| dlyLoad | input | 1 | Arms the delayed request |
| dlySrc | input | 16 | Flag mask set when the delayed request expires |
| dlyCount | input | 4 | Delay in cycles for the delayed request |
| haltWake | output | 1 | Wake-from-halt indication |
| irqLine | output | 1 | Processor interrupt request |

## Verification
Any corruption of a shadow or live register shows up on the read port one cycle after the update window copies it. It also reaches haltWake one cycle after that, and irqLine one more cycle later. An update window that stops too early leaves the history stale. That error then stays visible on the outputs indefinitely, because nothing shifts again until the next trigger. The bench keeps a cycle-level reference model and compares both outputs and the addressed read byte after every edge. A fault is therefore reported within one to three cycles of its cause.

// File: rtl/irq_delay_pkg.sv
package irq_delay_pkg;

  localparam int unsigned OFS_IE_LO  = 'h200;
  localparam int unsigned OFS_IE_HI  = 'h201;
  localparam int unsigned OFS_IF_LO  = 'h202;
  localparam int unsigned OFS_IF_HI  = 'h203;
  localparam int unsigned OFS_IME    = 'h208;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrIeLo;
    logic wrIeHi;
    logic wrIfLo;
    logic wrIfHi;
    logic wrIme;
    logic dlyLoad;
    logic dlyFire;
    logic advance;
  } irq_strobe_t;

endpackage

// File: rtl/irq_ctrl_ctl.sv
module irq_ctrl_ctl
  import irq_delay_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_SRC   = 16,
  parameter int UPD_DELAY = 3,
  parameter int DLY_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_SRC-1:0] reqPulse,
  input  logic               dlyLoad,
  input  logic [DLY_W-1:0]   dlyCount,
  output irq_strobe_t        st
);
  localparam int CNT_W = $clog2(UPD_DELAY + 1);

  logic [CNT_W-1:0] updCnt;
  logic [DLY_W-1:0] dlyCnt;
  logic             trigger;

  always_comb begin
    st         = '0;
    st.wrIeLo  = regWrEn && (regAddr == ADDR_W'(OFS_IE_LO));
    st.wrIeHi  = regWrEn && (regAddr == ADDR_W'(OFS_IE_HI));
    st.wrIfLo  = regWrEn && (regAddr == ADDR_W'(OFS_IF_LO));
    st.wrIfHi  = regWrEn && (regAddr == ADDR_W'(OFS_IF_HI));
    st.wrIme   = regWrEn && (regAddr == ADDR_W'(OFS_IME));
    st.dlyLoad = dlyLoad;
    st.dlyFire = (dlyCnt == DLY_W'(1));
    st.advance = (updCnt != '0);
    trigger    = st.wrIeLo | st.wrIeHi | st.wrIfLo | st.wrIfHi | st.wrIme
               | (|reqPulse) | st.dlyFire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      updCnt <= '0;
      dlyCnt <= '0;
    end else begin
      if (trigger)             updCnt <= CNT_W'(UPD_DELAY);
      else if (updCnt != '0)   updCnt <= updCnt - CNT_W'(1);

      if (dlyLoad)             dlyCnt <= dlyCount;
      else if (dlyCnt != '0)   dlyCnt <= dlyCnt - DLY_W'(1);
    end
  end

endmodule

// File: rtl/irq_ctrl_dp.sv
module irq_ctrl_dp
  import irq_delay_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  irq_strobe_t        st,
  input  logic [7:0]         wrData,
  input  logic [NUM_SRC-1:0] reqPulse,
  input  logic [NUM_SRC-1:0] dlySrc,
  output logic [NUM_SRC-1:0] liveIe,
  output logic [NUM_SRC-1:0] liveIf,
  output logic               liveIme,
  output logic               haltWake,
  output logic               irqLine
);
  logic [NUM_SRC-1:0] shIe, shIf, dlyMask;
  logic               shIme;
  logic [NUM_SRC-1:0] shIeNext, shIfNext, clrMask, setMask;
  logic [15:0]        ieWide, clrWide;
  logic               pendQ;
  logic [1:0]         lineHist;
  logic               anyLive;

  always_comb begin
    ieWide = 16'(shIe);
    if (st.wrIeLo) ieWide[7:0]  = wrData;
    if (st.wrIeHi) ieWide[15:8] = wrData;
    shIeNext = ieWide[NUM_SRC-1:0];

    clrWide = '0;
    if (st.wrIfLo) clrWide[7:0]  = wrData;
    if (st.wrIfHi) clrWide[15:8] = wrData;
    clrMask  = clrWide[NUM_SRC-1:0];
    setMask  = reqPulse | (st.dlyFire ? dlyMask : '0);
    shIfNext = (shIf & ~clrMask) | setMask;   // set beats clear

    anyLive  = |(liveIe & liveIf);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shIe     <= '0;
      shIf     <= '0;
      shIme    <= 1'b0;
      dlyMask  <= '0;
      liveIe   <= '0;
      liveIf   <= '0;
      liveIme  <= 1'b0;
      pendQ    <= 1'b0;
      lineHist <= '0;
    end else begin
      shIe <= shIeNext;
      shIf <= shIfNext;
      if (st.wrIme)   shIme   <= wrData[0];
      if (st.dlyLoad) dlyMask <= dlySrc;
      if (st.advance) begin
        pendQ    <= anyLive;
        lineHist <= {lineHist[0], anyLive & liveIme};
        liveIe   <= shIe;
        liveIf   <= shIf;
        liveIme  <= shIme;
      end
    end
  end

  assign haltWake = pendQ;
  assign irqLine  = lineHist[1];

endmodule

// File: rtl/irq_delay_ctrl.sv
module irq_delay_ctrl
  import irq_delay_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_SRC   = 16,
  parameter int UPD_DELAY = 3,
  parameter int DLY_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  input  logic [NUM_SRC-1:0] reqPulse,
  input  logic               dlyLoad,
  input  logic [NUM_SRC-1:0] dlySrc,
  input  logic [DLY_W-1:0]   dlyCount,
  output logic               haltWake,
  output logic               irqLine
);
  irq_strobe_t        st;
  logic [NUM_SRC-1:0] liveIe, liveIf;
  logic               liveIme;
  logic [15:0]        ieRd, ifRd;

  irq_ctrl_ctl #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .UPD_DELAY(UPD_DELAY), .DLY_W(DLY_W)
  ) i_ctl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .reqPulse(reqPulse), .dlyLoad(dlyLoad), .dlyCount(dlyCount), .st(st)
  );

  irq_ctrl_dp #(.NUM_SRC(NUM_SRC)) i_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .wrData(regWrData),
    .reqPulse(reqPulse), .dlySrc(dlySrc),
    .liveIe(liveIe), .liveIf(liveIf), .liveIme(liveIme),
    .haltWake(haltWake), .irqLine(irqLine)
  );

  always_comb begin
    ieRd = 16'(liveIe);
    ifRd = 16'(liveIf);
    if      (regAddr == ADDR_W'(OFS_IE_LO)) regRdData = ieRd[7:0];
    else if (regAddr == ADDR_W'(OFS_IE_HI)) regRdData = ieRd[15:8];
    else if (regAddr == ADDR_W'(OFS_IF_LO)) regRdData = ifRd[7:0];
    else if (regAddr == ADDR_W'(OFS_IF_HI)) regRdData = ifRd[15:8];
    else if (regAddr == ADDR_W'(OFS_IME))   regRdData = {7'b0, liveIme};
    else                                    regRdData = 8'h00;
  end

endmodule

// File: rtl/irq_delay_checker.sv
module irq_delay_checker #(
  parameter int ADDR_W  = 10,
  parameter int NUM_SRC = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [7:0]         regRdData,
  input logic [NUM_SRC-1:0] reqPulse,
  input logic               updActive,
  input logic [NUM_SRC-1:0] liveIe,
  input logic [NUM_SRC-1:0] liveIf,
  input logic               liveIme,
  input logic               haltWake,
  input logic               irqLine
);
  logic isReserved, isCtrlWr;
  assign isReserved = (regAddr == ADDR_W'('h206)) || (regAddr == ADDR_W'('h207)) ||
                      (regAddr == ADDR_W'('h209)) || (regAddr == ADDR_W'('h20A)) ||
                      (regAddr == ADDR_W'('h20B));
  assign isCtrlWr = regWrEn && ((regAddr == ADDR_W'('h200)) || (regAddr == ADDR_W'('h201)) ||
                                (regAddr == ADDR_W'('h202)) || (regAddr == ADDR_W'('h203)) ||
                                (regAddr == ADDR_W'('h208)));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    isReserved |-> (regRdData == 8'h00));

  assert_ime_onebit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == ADDR_W'('h208)) |-> (regRdData[7:1] == 7'h00));

  assert_window_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (isCtrlWr || (|reqPulse)) |=> updActive);

  assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !updActive |=> ($stable(liveIe) && $stable(liveIf) && $stable(liveIme)
                    && $stable(haltWake) && $stable(irqLine)));

  assert_line_after_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqLine) |-> $past(haltWake));

endmodule

bind irq_delay_ctrl irq_delay_checker #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
  .regRdData(regRdData), .reqPulse(reqPulse), .updActive(st.advance),
  .liveIe(liveIe), .liveIf(liveIf), .liveIme(liveIme),
  .haltWake(haltWake), .irqLine(irqLine)
);

// File: tb/test_irq_delay_ctrl.sv
`timescale 1ns/1ps
module test_irq_delay_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        regWrEn;
  logic [9:0]  regAddr;
  logic [7:0]  regWrData, regRdData;
  logic [15:0] reqPulse, dlySrc;
  logic        dlyLoad;
  logic [3:0]  dlyCount;
  logic        haltWake, irqLine;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  logic [15:0] mShIe, mShIf, mIe, mIf, mDlySrc;
  logic        mShIme, mIme, mPend;
  logic [1:0]  mLine;
  int          mCnt, mDly;

  always #2.5 clk = ~clk;

  irq_delay_ctrl i_irq_delay_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqPulse(reqPulse),
    .dlyLoad(dlyLoad), .dlySrc(dlySrc), .dlyCount(dlyCount),
    .haltWake(haltWake), .irqLine(irqLine)
  );

  function automatic logic [7:0] mRead(input logic [9:0] a);
    case (a)
      10'h200: return mIe[7:0];
      10'h201: return mIe[15:8];
      10'h202: return mIf[7:0];
      10'h203: return mIf[15:8];
      10'h208: return {7'b0, mIme};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mShIe = 0; mShIf = 0; mIe = 0; mIf = 0; mDlySrc = 0;
    mShIme = 0; mIme = 0; mPend = 0; mLine = 0; mCnt = 0; mDly = 0;
  endtask

  task automatic modelEdge(input logic we, input logic [9:0] a, input logic [7:0] d,
                           input logic [15:0] rq, input logic dl, input logic [15:0] ds,
                           input logic [3:0] dc);
    logic fire, trig, ctrl, adv, any;
    logic [15:0] clr, setm;
    fire = (mDly == 1);
    ctrl = we && (a == 10'h200 || a == 10'h201 || a == 10'h202 || a == 10'h203 || a == 10'h208);
    trig = ctrl || (rq != 0) || fire;
    adv  = (mCnt != 0);
    any  = ((mIe & mIf) != 0);
    if (adv) begin
      mPend = any;
      mLine = {mLine[0], any & mIme};
      mIe = mShIe; mIf = mShIf; mIme = mShIme;
    end
    clr = 0;
    if (we && a == 10'h202) clr[7:0]  = d;
    if (we && a == 10'h203) clr[15:8] = d;
    setm = rq | (fire ? mDlySrc : 16'h0);
    mShIf = (mShIf & ~clr) | setm;
    if (we && a == 10'h200) mShIe[7:0]  = d;
    if (we && a == 10'h201) mShIe[15:8] = d;
    if (we && a == 10'h208) mShIme = d[0];
    mCnt = trig ? 3 : (adv ? mCnt - 1 : 0);
    if (dl) begin mDly = int'(dc); mDlySrc = ds; end
    else if (mDly != 0) mDly = mDly - 1;
  endtask

  // one clock: drive, advance, compare everything against the model
  task automatic step(input logic we, input logic [9:0] a, input logic [7:0] d,
                      input logic [15:0] rq = 0, input logic dl = 0,
                      input logic [15:0] ds = 0, input logic [3:0] dc = 0);
    regWrEn = we; regAddr = a; regWrData = d; reqPulse = rq;
    dlyLoad = dl; dlySrc = ds; dlyCount = dc;
    @(posedge clk);
    modelEdge(we, a, d, rq, dl, ds, dc);
    @(negedge clk);
    regWrEn = 0; reqPulse = 0; dlyLoad = 0;
    #0.1;
    chk("R6", "haltWake", int'(haltWake), int'(mPend));
    chk("R7", "irqLine", int'(irqLine), int'(mLine[1]));
    chk("R2", "readback", int'(regRdData), int'(mRead(a)));
  endtask

  task automatic idle(input logic [9:0] a);
    step(0, a, 8'h00);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 0; regWrEn = 0; regAddr = 10'h200; regWrData = 0;
    reqPulse = 0; dlyLoad = 0; dlySrc = 0; dlyCount = 0;
    modelReset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #0.1;
    // R1: reset state
    chk("R1", "haltWake", int'(haltWake), 0);
    chk("R1", "irqLine", int'(irqLine), 0);
    chk("R1", "IE lo", int'(regRdData), 0);

    // R4: write visible one edge late
    step(1, 10'h200, 8'h05);
    chk("R4", "IE lo right after write", int'(regRdData), 0);
    idle(10'h200);
    chk("R4", "IE lo one edge later", int'(regRdData), 'h05);
    step(1, 10'h201, 8'h80);
    idle(10'h201);
    chk("R2", "IE hi", int'(regRdData), 'h80);

    // R6/R8: request on bit 0, master enable off
    step(0, 10'h202, 8'h00, 16'h0001);
    chk("R6", "IF before copy", int'(regRdData), 0);
    idle(10'h202);
    chk("R6", "IF live", int'(regRdData), 1);
    chk("R6", "wake not yet", int'(haltWake), 0);
    idle(10'h202);
    chk("R6", "wake two edges after", int'(haltWake), 1);
    chk("R8", "line held low", int'(irqLine), 0);
    repeat (3) idle(10'h202);
    chk("R8", "line still low", int'(irqLine), 0);

    // R7: master enable on
    step(1, 10'h208, 8'hFF);
    idle(10'h208);
    chk("R7", "line E", int'(irqLine), 0);
    chk("R2", "IME one bit", int'(regRdData), 1);
    idle(10'h208);
    chk("R7", "line F", int'(irqLine), 0);
    idle(10'h208);
    chk("R7", "line G", int'(irqLine), 1);

    // R3: write-one-to-clear, per byte
    step(1, 10'h202, 8'h01);
    chk("R3", "wake at write", int'(haltWake), 1);
    idle(10'h202);
    chk("R3", "IF lo cleared", int'(regRdData), 0);
    chk("R6", "wake lag", int'(haltWake), 1);
    idle(10'h202);
    chk("R6", "wake fell", int'(haltWake), 0);
    chk("R7", "line lag", int'(irqLine), 1);
    idle(10'h202);
    chk("R7", "line fell", int'(irqLine), 0);
    step(0, 10'h202, 8'h00, 16'h0202);
    step(1, 10'h203, 8'h02);
    idle(10'h203);
    chk("R3", "IF hi cleared", int'(regRdData), 0);
    idle(10'h202);
    chk("R3", "IF lo kept", int'(regRdData), 'h02);

    // R10: clear and set of the same bit together
    step(1, 10'h202, 8'h02);
    idle(10'h202);
    chk("R10", "bit1 cleared first", int'(regRdData), 0);
    step(1, 10'h202, 8'h02, 16'h0002);
    idle(10'h202);
    chk("R10", "set wins", int'(regRdData), 'h02);

    // R9: delayed request
    step(0, 10'h202, 8'h00, 16'h0000, 1, 16'h0008, 4'd4);
    for (int i = 0; i < 4; i++) begin
      idle(10'h202);
      chk("R9", "delayed not yet", int'(regRdData[3]), 0);
    end
    idle(10'h202);
    chk("R9", "delayed fired", int'(regRdData[3]), 1);
    step(0, 10'h202, 8'h00, 16'h0000, 1, 16'h0010, 4'd0);
    for (int i = 0; i < 8; i++) idle(10'h202);
    chk("R9", "count zero inert", int'(regRdData[4]), 0);

    // R2: reserved offsets
    step(1, 10'h206, 8'hFF);
    chk("R2", "0x206 reads 0", int'(regRdData), 0);
    step(1, 10'h209, 8'hFF);
    idle(10'h20B);
    chk("R2", "0x20B reads 0", int'(regRdData), 0);
    idle(10'h200);
    chk("R2", "IE lo untouched", int'(regRdData), 'h05);

    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [9:0]  a;
      logic [15:0] rq;
      int sel;
      sel = int'($urandom % 9);
      case (sel)
        0: a = 10'h200; 1: a = 10'h201; 2: a = 10'h202; 3: a = 10'h203;
        4: a = 10'h208; 5: a = 10'h206; 6: a = 10'h20A; 7: a = 10'h100;
        default: a = 10'h202;
      endcase
      rq = ($urandom % 6 == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
      step(($urandom % 3) == 0, a, 8'($urandom), rq,
           ($urandom % 20) == 0, 16'($urandom), 4'($urandom % 7));
    end

    finish_run();
  end
endmodule